// File: doc/BRIEF.md
# Boot Vector Fetch and Remap Controller

This block runs once after every reset, placed between a processor core and the memory bus. On the first clock after reset is released it captures two configuration straps. One strap picks the boot source (user table or internal loader). The other picks the vector base address. In user mode it reads a small table of words from the chosen base. It takes the first word as the initial stack pointer and the second as the initial program counter, and it sums all table words to check them. While it works it holds the core in reset. It then releases the core with a stack pointer and program counter that are either taken from the table or, when the table is rejected, fixed loader entry values.

The block also decodes the low address window. After reset, accesses there select the boot ROM. Once boot is complete, software may set a remap bit, and from then on the same window selects RAM until the next reset.

Top module: `boot_vector_ctrl`

## Requirements
- R1: `strap_loader` and `strap_alt_base` are sampled on the first rising clock edge after `rst_n` goes high and held until the next reset; later changes on these pins do not alter the boot outcome or the fetch addresses.
- R2: The table base is 0x00000000 when the latched `strap_alt_base` is 0 and 0xFFFF0000 when it is 1.
- R3: On a valid table, `init_sp` equals the word read at the base and `init_pc` equals the word read at base + 4.
- R4: Table reads go out one at a time, at the addresses base + 4*i for i = 0..7 in ascending order. `rd_valid` and `rd_addr` hold steady until `rd_ready` is seen high, and `rd_data` is taken on the edge where both are high.
- R5: When the latched `strap_loader` is 1, no bus read is issued, `from_loader` is 1, and `init_sp`/`init_pc` carry the loader values (defaults 0x20000400 and 0x00100040).
- R6: The table is accepted only when the 32-bit wrapping sum of the 8 words is zero.
- R7: A rejected table gives `table_invalid` = 1, `from_loader` = 1 and the loader `init_sp`/`init_pc`.
- R8: A reset-vector word (base + 4) of 0xFFFFFFFF rejects the table even when the sum is zero.
- R9: `core_hold` is 1 and `boot_done` is 0 from reset until the outcome is decided; then `boot_done` goes to 1, `core_hold` to 0, and both stay there together with the final `init_sp`/`init_pc` until the next reset.
- R10: For `map_addr` below 0x1000, `sel_rom` is 1 while the remap bit is 0 and `sel_ram` is 1 while it is 1; above the window both are 0.
- R11: A write with `cfg_wr_en` = 1 and `cfg_wr_remap` = 1 sets the remap bit only when `boot_done` is 1. A write before then has no effect. Writing 0 never clears the bit; only reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_loader | input | 1 | Boot source strap, 1 = internal loader |
| strap_alt_base | input | 1 | Vector base strap, 1 = high base |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | 32 | Read byte address |
| rd_ready | input | 1 | Read data valid / request accepted |
| rd_data | input | 32 | Read data word |
| core_hold | output | 1 | Holds the core in reset |
| boot_done | output | 1 | Boot outcome decided |
| init_sp | output | 32 | Initial stack pointer for the core |
| init_pc | output | 32 | Initial program counter for the core |
| from_loader | output | 1 | Core starts in the internal loader |
| table_invalid | output | 1 | User table was rejected |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_remap | input | 1 | Remap bit value written |
| map_addr | input | 32 | Address to decode for the low window |
| sel_rom | output | 1 | Low window maps to boot ROM |
| sel_ram | output | 1 | Low window maps to RAM |
| remap_on | output | 1 | Current remap bit |

## Verification
The assertions assume that the memory side answers every read: `rd_ready` is only asserted while `rd_valid` is high, and it comes within a bounded wait. They also assume that `rd_data` is meaningful on the handshake edge. The bench memory model respects this. It raises `rd_ready` for one cycle, a fixed number of cycles after it sees a request, and it drives the data from a table selected by the top address bit. It drops `rd_ready` right after each handshake. Straps and register writes are driven on falling edges, so each change meets a known sampling edge.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_FETCH = 2'd1,
    ST_JUDGE = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;

  // wrapping accumulation of table words
  function automatic word_t sum_step(input word_t acc, input word_t w);
    return acc + w;
  endfunction

  // erased-flash pattern for a vector
  function automatic logic is_erased(input word_t w);
    return &w;
  endfunction

  function automatic word_t pick_base(input logic alt, input word_t lo, input word_t hi);
    return alt ? hi : lo;
  endfunction
endpackage

// File: rtl/bvc_strap_latch.sv
module bvc_strap_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_loader,
  input  logic strap_alt_base,
  output logic armed,
  output logic loader_q,
  output logic alt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      loader_q <= 1'b0;
      alt_q    <= 1'b0;
    end else if (!armed) begin
      armed    <= 1'b1;
      loader_q <= strap_loader;
      alt_q    <= strap_alt_base;
    end
  end

  a_r1_straps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed && $stable(loader_q) && $stable(alt_q));
endmodule

// File: rtl/bvc_csum.sv
module bvc_csum
  import boot_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  word_t word,
  output logic  sum_zero
);
  word_t acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else if (take) acc_q <= sum_step(acc_q, word);
  end

  assign sum_zero = (acc_q == '0);
endmodule

// File: rtl/bvc_fetch_seq.sv
module bvc_fetch_seq
  import boot_pkg::*;
#(
  parameter int    TABLE_WORDS = 8,
  parameter word_t BASE_LO     = 32'h0000_0000,
  parameter word_t BASE_HI     = 32'hFFFF_0000,
  parameter word_t LOADER_SP   = 32'h2000_0400,
  parameter word_t LOADER_PC   = 32'h0010_0040
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  armed,
  input  logic  loader_q,
  input  logic  alt_q,
  output logic  rd_valid,
  output word_t rd_addr,
  input  logic  rd_ready,
  input  word_t rd_data,
  output logic  word_take,
  input  logic  sum_zero,
  output logic  boot_done,
  output word_t init_sp,
  output word_t init_pc,
  output logic  from_loader,
  output logic  table_invalid
);
  localparam int IDX_W    = $clog2(TABLE_WORDS);
  localparam int BYTE_SH  = $clog2(WORD_W / 8);
  localparam int LAST_IDX = TABLE_WORDS - 1;

  seq_state_t state_q;
  logic [IDX_W-1:0] idx_q;
  word_t sp_q, pc_q;
  logic  table_ok;

  assign rd_valid  = (state_q == ST_FETCH);
  assign rd_addr   = pick_base(alt_q, BASE_LO, BASE_HI) + (word_t'(idx_q) << BYTE_SH);
  assign word_take = rd_valid && rd_ready;
  assign table_ok  = sum_zero && !is_erased(pc_q);
  assign boot_done = (state_q == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_WAIT;
      idx_q         <= '0;
      sp_q          <= '0;
      pc_q          <= '0;
      init_sp       <= '0;
      init_pc       <= '0;
      from_loader   <= 1'b0;
      table_invalid <= 1'b0;
    end else begin
      case (state_q)
        ST_WAIT: if (armed) begin
          if (loader_q) begin
            init_sp     <= LOADER_SP;
            init_pc     <= LOADER_PC;
            from_loader <= 1'b1;
            state_q     <= ST_DONE;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: if (word_take) begin
          if (idx_q == IDX_W'(0)) sp_q <= rd_data;
          if (idx_q == IDX_W'(1)) pc_q <= rd_data;
          if (idx_q == IDX_W'(LAST_IDX)) state_q <= ST_JUDGE;
          else idx_q <= idx_q + 1'b1;
        end
        ST_JUDGE: begin
          if (table_ok) begin
            init_sp <= sp_q;
            init_pc <= pc_q;
          end else begin
            init_sp       <= LOADER_SP;
            init_pc       <= LOADER_PC;
            from_loader   <= 1'b1;
            table_invalid <= 1'b1;
          end
          state_q <= ST_DONE;
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  a_r5_loader_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    loader_q |-> !rd_valid);
  a_r7_reject_entry: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done && table_invalid |-> init_pc == LOADER_PC && from_loader);
  a_r8_no_erased_start: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done && !from_loader |-> !is_erased(init_pc));
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done && $stable(init_pc) && $stable(init_sp));
endmodule

// File: rtl/bvc_remap.sv
module bvc_remap
  import boot_pkg::*;
#(
  parameter word_t WINDOW = 32'h0000_1000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  boot_done,
  input  logic  cfg_wr_en,
  input  logic  cfg_wr_remap,
  input  word_t map_addr,
  output logic  sel_rom,
  output logic  sel_ram,
  output logic  remap_on
);
  logic in_window;

  always_ff @(posedge clk) begin
    if (!rst_n) remap_on <= 1'b0;
    else if (cfg_wr_en && cfg_wr_remap && boot_done) remap_on <= 1'b1;
  end

  assign in_window = (map_addr < WINDOW);
  assign sel_rom   = in_window && !remap_on;
  assign sel_ram   = in_window && remap_on;

  a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel_rom, sel_ram}) <= 1);
  a_r11_set_only: assert property (@(posedge clk) disable iff (!rst_n)
    remap_on |=> remap_on);
  a_r11_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(remap_on) |-> $past(boot_done));
endmodule

// File: rtl/boot_vector_ctrl.sv
module boot_vector_ctrl
  import boot_pkg::*;
#(
  parameter int    TABLE_WORDS = 8,
  parameter word_t BASE_LO     = 32'h0000_0000,
  parameter word_t BASE_HI     = 32'hFFFF_0000,
  parameter word_t LOADER_SP   = 32'h2000_0400,
  parameter word_t LOADER_PC   = 32'h0010_0040,
  parameter word_t WINDOW      = 32'h0000_1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_loader,
  input  logic        strap_alt_base,
  output logic        rd_valid,
  output logic [31:0] rd_addr,
  input  logic        rd_ready,
  input  logic [31:0] rd_data,
  output logic        core_hold,
  output logic        boot_done,
  output logic [31:0] init_sp,
  output logic [31:0] init_pc,
  output logic        from_loader,
  output logic        table_invalid,
  input  logic        cfg_wr_en,
  input  logic        cfg_wr_remap,
  input  logic [31:0] map_addr,
  output logic        sel_rom,
  output logic        sel_ram,
  output logic        remap_on
);
  logic armed, loader_q, alt_q, word_take, sum_zero;

  bvc_strap_latch u_straps (
    .clk(clk), .rst_n(rst_n),
    .strap_loader(strap_loader), .strap_alt_base(strap_alt_base),
    .armed(armed), .loader_q(loader_q), .alt_q(alt_q)
  );

  bvc_csum u_csum (
    .clk(clk), .rst_n(rst_n), .take(word_take), .word(rd_data), .sum_zero(sum_zero)
  );

  bvc_fetch_seq #(
    .TABLE_WORDS(TABLE_WORDS), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI),
    .LOADER_SP(LOADER_SP), .LOADER_PC(LOADER_PC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .armed(armed), .loader_q(loader_q), .alt_q(alt_q),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
    .word_take(word_take), .sum_zero(sum_zero), .boot_done(boot_done),
    .init_sp(init_sp), .init_pc(init_pc), .from_loader(from_loader),
    .table_invalid(table_invalid)
  );

  bvc_remap #(.WINDOW(WINDOW)) u_remap (
    .clk(clk), .rst_n(rst_n), .boot_done(boot_done),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_remap(cfg_wr_remap), .map_addr(map_addr),
    .sel_rom(sel_rom), .sel_ram(sel_ram), .remap_on(remap_on)
  );

  assign core_hold = !boot_done;

  a_r9_release_with_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_done) |-> !core_hold && (from_loader || init_pc != '1));
endmodule

// File: tb/boot_vector_ctrl_test.sv
module boot_vector_ctrl_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, strap_loader = 1'b0, strap_alt_base = 1'b0;
  logic        rd_valid, rd_ready = 1'b0;
  logic [31:0] rd_addr, rd_data = '0;
  logic        core_hold, boot_done, from_loader, table_invalid;
  logic [31:0] init_sp, init_pc;
  logic        cfg_wr_en = 1'b0, cfg_wr_remap = 1'b0;
  logic [31:0] map_addr = '0;
  logic        sel_rom, sel_ram, remap_on;

  boot_vector_ctrl uut (.*);

  localparam logic [31:0] LSP = 32'h2000_0400, LPC = 32'h0010_0040;

  int vectors = 0, misses = 0;
  logic [31:0] tab_lo [8];
  logic [31:0] tab_hi [8];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder: answers after a fixed wait, one cycle of ready
  int wcnt = 0;
  always @(negedge clk) begin
    if (!rd_valid || rd_ready) begin
      rd_ready <= 1'b0;
      wcnt <= 0;
    end else if (wcnt == 2) begin
      rd_ready <= 1'b1;
      rd_data  <= rd_addr[31] ? tab_hi[rd_addr[4:2]] : tab_lo[rd_addr[4:2]];
    end else begin
      wcnt <= wcnt + 1;
    end
  end

  // read monitor
  logic clr_mon = 1'b0;
  int nreads = 0, order_err = 0;
  logic [31:0] first_addr = '0, prev_addr = '0;
  always @(posedge clk) begin
    if (clr_mon) begin
      nreads <= 0; order_err <= 0;
    end else if (rd_valid && rd_ready) begin
      if (nreads == 0) first_addr <= rd_addr;
      else if (rd_addr != prev_addr + 4) order_err <= order_err + 1;
      prev_addr <= rd_addr;
      nreads <= nreads + 1;
    end
  end

  // fill a table so that the wrapping word sum is zero
  task automatic fill(input bit hi, input logic [31:0] sp, input logic [31:0] pc, input bit spoil);
    logic [31:0] w [8];
    logic [31:0] tot;
    w[0] = sp; w[1] = pc;
    for (int i = 2; i < 7; i++) w[i] = 32'h1111_0000 * i + 32'h0000_0ABC;
    tot = 0;
    for (int i = 0; i < 7; i++) tot = tot + w[i];
    w[7] = ~tot + 1;
    if (spoil) w[7] = w[7] ^ 32'h0000_0100;
    for (int i = 0; i < 8; i++) begin
      if (hi) tab_hi[i] = w[i]; else tab_lo[i] = w[i];
    end
  endtask

  task automatic start_boot(input logic ldr, input logic alt);
    @(negedge clk);
    rst_n = 1'b0; clr_mon = 1'b1;
    strap_loader = ldr; strap_alt_base = alt;
    repeat (3) @(negedge clk);
    clr_mon = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!boot_done && n < 300) begin @(negedge clk); n++; end
    if (!boot_done) begin
      misses++; vectors++;
      $display("FAIL R9: boot_done never rose, actual 0 expected 1");
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    start_boot(1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 hold in reset", {31'd0, core_hold}, 32'd1);
    chk("R9 done in reset", {31'd0, boot_done}, 32'd0);
    chk("R11 remap in reset", {31'd0, remap_on}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 hold during fetch", {31'd0, core_hold}, 32'd1);
    wait_done();
  endtask

  task automatic t_user_ok();
    fill(1'b0, 32'h2000_8000, 32'h0000_0201, 1'b0);
    start_boot(1'b0, 1'b0);
    wait_done();
    chk("R3 sp", init_sp, 32'h2000_8000);
    chk("R3 pc", init_pc, 32'h0000_0201);
    chk("R6 valid", {31'd0, table_invalid}, 32'd0);
    chk("R6 user start", {31'd0, from_loader}, 32'd0);
    chk("R2 low base", first_addr, 32'h0000_0000);
    chk("R4 read count", nreads, 32'd8);
    chk("R4 ascending", order_err, 32'd0);
    chk("R9 released", {31'd0, core_hold}, 32'd0);
  endtask

  task automatic t_alt_base();
    fill(1'b1, 32'h3000_0100, 32'hFFFF_0401, 1'b0);
    start_boot(1'b0, 1'b1);
    wait_done();
    chk("R2 high base", first_addr, 32'hFFFF_0000);
    chk("R3 sp alt", init_sp, 32'h3000_0100);
    chk("R3 pc alt", init_pc, 32'hFFFF_0401);
    chk("R4 last addr", prev_addr, 32'hFFFF_001C);
  endtask

  task automatic t_bad_sum();
    fill(1'b0, 32'h2000_8000, 32'h0000_0201, 1'b1);
    start_boot(1'b0, 1'b0);
    wait_done();
    chk("R7 invalid flag", {31'd0, table_invalid}, 32'd1);
    chk("R7 loader flag", {31'd0, from_loader}, 32'd1);
    chk("R7 loader pc", init_pc, LPC);
    chk("R7 loader sp", init_sp, LSP);
  endtask

  task automatic t_erased();
    fill(1'b0, 32'h2000_8000, 32'hFFFF_FFFF, 1'b0);
    start_boot(1'b0, 1'b0);
    wait_done();
    chk("R8 erased invalid", {31'd0, table_invalid}, 32'd1);
    chk("R8 erased pc", init_pc, LPC);
  endtask

  task automatic t_loader_strap();
    fill(1'b0, 32'h2000_8000, 32'h0000_0201, 1'b0);
    start_boot(1'b1, 1'b0);
    wait_done();
    chk("R5 no reads", nreads, 32'd0);
    chk("R5 loader flag", {31'd0, from_loader}, 32'd1);
    chk("R5 loader pc", init_pc, LPC);
    chk("R5 loader sp", init_sp, LSP);
    chk("R5 not invalid", {31'd0, table_invalid}, 32'd0);
  endtask

  task automatic t_strap_late();
    fill(1'b0, 32'h2000_8000, 32'h0000_0201, 1'b0);
    start_boot(1'b0, 1'b0);
    @(negedge clk);
    strap_loader = 1'b1; strap_alt_base = 1'b1;
    wait_done();
    chk("R1 base kept", first_addr, 32'h0000_0000);
    chk("R1 user kept", init_pc, 32'h0000_0201);
    chk("R1 source kept", {31'd0, from_loader}, 32'd0);
    strap_loader = 1'b0; strap_alt_base = 1'b0;
  endtask

  task automatic t_remap();
    fill(1'b0, 32'h2000_8000, 32'h0000_0201, 1'b0);
    start_boot(1'b0, 1'b0);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_remap = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    wait_done();
    map_addr = 32'h0000_0010;
    #1;
    chk("R11 early write ignored", {30'd0, sel_rom, sel_ram}, 32'd2);
    chk("R10 rom at zero", {31'd0, sel_rom}, 32'd1);
    cfg_wr_en = 1'b1; cfg_wr_remap = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    #1;
    chk("R10 ram after remap", {30'd0, sel_rom, sel_ram}, 32'd1);
    map_addr = 32'h0000_2000;
    #1;
    chk("R10 outside window", {30'd0, sel_rom, sel_ram}, 32'd0);
    cfg_wr_en = 1'b1; cfg_wr_remap = 1'b0;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    chk("R11 zero write keeps", {31'd0, remap_on}, 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reset clears", {31'd0, remap_on}, 32'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin tab_lo[i] = '0; tab_hi[i] = '0; end
    t_reset();
    t_user_ok();
    t_alt_base();
    t_bad_sum();
    t_erased();
    t_loader_strap();
    t_strap_late();
    t_remap();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    misses++; vectors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule